// File: doc/BRIEF.md
# Schedule Base Time Adjuster

This block picks the start time that a time-aware gate schedule is actually armed with. It is given the present network time in nanoseconds, the start time that was asked for, and the schedule's cycle length. If the requested start is far enough ahead, it is used as is. Otherwise the block moves it forward so that it lies at least two cycles beyond the present time. Where the requested start is already in the past, the moved start keeps the phase of the original schedule.

The result is a single nanosecond count. The block then breaks it into a nanosecond-of-second field, a low seconds word and a high seconds word, which are ready to be written to a schedule start register. Both the phase remainder and the seconds split come from one shared restoring divider. That divider produces one quotient bit per clock. A one-cycle start pulse launches a computation. The block raises busy while it works, gives a one-cycle done pulse when the fields are valid, and holds those fields until the next result.

Top module: `sched_base_time_adj`

## Requirements
- R1: With threshold T = curTime + 2*cycleTime, a requested time reqTime >= T is produced unchanged. Equality with T counts as this case.
- R2: When reqTime <= curTime, let E = curTime - reqTime and let M = E mod cycleTime if E > cycleTime, otherwise M = 0. The result is T + cycleTime - M.
- R3: When curTime < reqTime < T, the result is reqTime + 2*cycleTime.
- R4: nsField (30 bits) is the result mod 1,000,000,000. secLo is bits 31:0 and secHi is bits 47:32 of the result divided by 1,000,000,000.
- R5: A start seen while busy is low is accepted on that clock edge. busy is high from the next cycle until completion. done is high for exactly one cycle, and busy is already low in that cycle.
- R6: Counting the clock edges after the accepting edge, done shows after edge 2+TIME_W when no remainder is needed. It shows after edge 3+2*TIME_W when R2 calls for a remainder (E > cycleTime).
- R7: A start pulse that arrives while busy is high is ignored. The running computation keeps its result and its timing.
- R8: After reset busy, done and all output fields are zero. The output fields change only in the cycle in which done is high.
- R9: Boundary inputs follow the same rules. reqTime == curTime gives T + cycleTime. E == cycleTime gives T + cycleTime. E that is an exact multiple of cycleTime gives T + cycleTime.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, sampled when idle |
| curTime | input | TIME_W | Present network time in ns |
| reqTime | input | TIME_W | Requested schedule start in ns |
| cycleTime | input | CYC_W | Schedule cycle length in ns, 1..999,999,999 |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle pulse when the output fields are valid |
| nsField | output | 30 | Nanosecond-of-second of the result |
| secLo | output | 32 | Seconds of the result, bits 31:0 |
| secHi | output | 16 | Seconds of the result, bits 47:32 |

## Verification
The checker watches the handshake on every cycle. It checks that a start taken while idle raises busy, that done is a single-cycle pulse with busy low, and that the output fields never move outside a done cycle. It also checks that the nanosecond field stays below one second. The choice among the three placement rules, the phase remainder, the exact latency of each path and the discarding of a start issued mid-run can only be shown by the bench's scenarios. The bench covers each boundary of the threshold comparison, elapsed times equal to or a multiple of the cycle, and the largest allowed cycle.

// File: rtl/bta_pkg.sv
package bta_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CASE, ST_MOD, ST_ADJ, ST_SPLIT, ST_FIN
  } state_t;

  typedef struct packed {
    logic capture;     // latch operands
    logic loadMod;     // divider: elapsed / cycle
    logic loadDirect;  // divider: case result / 1e9
    logic loadAdj;     // divider: phase-adjusted result / 1e9
    logic step;        // one restoring step
    logic publish;     // copy divider outcome to outputs
  } strobe_t;

  typedef struct packed {
    logic needMod;
    logic divLast;
  } status_t;
endpackage

// File: rtl/bta_ctrl.sv
module bta_ctrl
  import bta_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    start,
  input  status_t stat,
  output strobe_t strb,
  output logic    busy,
  output logic    done
);
  state_t state, nextState;

  always_comb begin
    strb = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: if (start) begin
        strb.capture = 1'b1;
        nextState = ST_CASE;
      end
      ST_CASE: if (stat.needMod) begin
        strb.loadMod = 1'b1;
        nextState = ST_MOD;
      end else begin
        strb.loadDirect = 1'b1;
        nextState = ST_SPLIT;
      end
      ST_MOD: begin
        strb.step = 1'b1;
        if (stat.divLast) nextState = ST_ADJ;
      end
      ST_ADJ: begin
        strb.loadAdj = 1'b1;
        nextState = ST_SPLIT;
      end
      ST_SPLIT: begin
        strb.step = 1'b1;
        if (stat.divLast) nextState = ST_FIN;
      end
      ST_FIN: begin
        strb.publish = 1'b1;
        nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nextState;
      done  <= strb.publish;
    end
  end

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/bta_dp.sv
module bta_dp
  import bta_pkg::*;
#(
  parameter int TIME_W     = 64,
  parameter int CYC_W      = 32,
  parameter int NS_PER_SEC = 1000000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [TIME_W-1:0] curTime,
  input  logic [TIME_W-1:0] reqTime,
  input  logic [CYC_W-1:0]  cycleTime,
  output status_t           stat,
  output logic [29:0]       nsField,
  output logic [47:0]       secField
);
  localparam int DEN_W = CYC_W;
  localparam int CNT_W = $clog2(TIME_W);

  logic [TIME_W-1:0] curQ, reqQ;
  logic [CYC_W-1:0]  cycQ;
  logic [TIME_W-1:0] divNum;
  logic [DEN_W-1:0]  divRem, divDen;
  logic [CNT_W-1:0]  cnt;

  // case evaluation on the captured operands
  logic [TIME_W-1:0] cycExt, thresh, elapsed, directVal, adjVal;
  logic reqGeThr, reqLeCur, elGtCyc;

  always_comb begin
    cycExt    = TIME_W'(cycQ);
    thresh    = curQ + (cycExt << 1);
    elapsed   = curQ - reqQ;
    reqGeThr  = (reqQ >= thresh);
    reqLeCur  = (reqQ <= curQ);
    elGtCyc   = (elapsed > cycExt);
    if (reqGeThr)      directVal = reqQ;
    else if (reqLeCur) directVal = thresh + cycExt;
    else               directVal = reqQ + (cycExt << 1);
    adjVal    = thresh + cycExt - TIME_W'(divRem);
  end

  assign stat.needMod = !reqGeThr && reqLeCur && elGtCyc;
  assign stat.divLast = (cnt == CNT_W'(TIME_W - 1));

  // one restoring step
  logic [DEN_W:0]   shifted;
  logic [DEN_W-1:0] diff, stepRem;
  logic             geBit;

  always_comb begin
    shifted = {divRem, divNum[TIME_W-1]};
    geBit   = (shifted >= {1'b0, divDen});
    diff    = shifted[DEN_W-1:0] - divDen;
    stepRem = geBit ? diff : shifted[DEN_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curQ     <= '0;
      reqQ     <= '0;
      cycQ     <= '0;
      divNum   <= '0;
      divRem   <= '0;
      divDen   <= '0;
      cnt      <= '0;
      nsField  <= '0;
      secField <= '0;
    end else begin
      if (strb.capture) begin
        curQ <= curTime;
        reqQ <= reqTime;
        cycQ <= cycleTime;
      end
      if (strb.loadMod || strb.loadDirect || strb.loadAdj) begin
        divRem <= '0;
        cnt    <= '0;
        divDen <= strb.loadMod ? cycQ : DEN_W'(NS_PER_SEC);
        divNum <= strb.loadMod ? elapsed : (strb.loadAdj ? adjVal : directVal);
      end else if (strb.step) begin
        divRem <= stepRem;
        divNum <= {divNum[TIME_W-2:0], geBit};
        cnt    <= cnt + 1'b1;
      end
      if (strb.publish) begin
        nsField  <= 30'(divRem);
        secField <= 48'(divNum);
      end
    end
  end
endmodule

// File: rtl/sched_base_time_adj.sv
module sched_base_time_adj
  import bta_pkg::*;
#(
  parameter int TIME_W     = 64,
  parameter int CYC_W      = 32,
  parameter int NS_PER_SEC = 1000000000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [TIME_W-1:0] curTime,
  input  logic [TIME_W-1:0] reqTime,
  input  logic [CYC_W-1:0]  cycleTime,
  output logic              busy,
  output logic              done,
  output logic [29:0]       nsField,
  output logic [31:0]       secLo,
  output logic [15:0]       secHi
);
  strobe_t     strb;
  status_t     stat;
  logic [47:0] secField;

  bta_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .stat(stat),
    .strb(strb), .busy(busy), .done(done)
  );

  bta_dp #(.TIME_W(TIME_W), .CYC_W(CYC_W), .NS_PER_SEC(NS_PER_SEC)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .curTime(curTime),
    .reqTime(reqTime), .cycleTime(cycleTime), .stat(stat),
    .nsField(nsField), .secField(secField)
  );

  assign secLo = secField[31:0];
  assign secHi = secField[47:32];
endmodule

// File: rtl/bta_chk.sv
module bta_chk (
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [29:0] nsField,
  input logic [31:0] secLo,
  input logic [15:0] secHi
);
  // R5
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8
  hold_outputs_chk: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(nsField) && $stable(secLo) && $stable(secHi)));

  // R4
  ns_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (nsField < 30'd1000000000));

  // R7
  busy_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |-> $past(busy) || $past(start));
endmodule

bind sched_base_time_adj bta_chk u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .nsField(nsField), .secLo(secLo), .secHi(secHi)
);

// File: tb/sched_base_time_adj_tb.sv
module sched_base_time_adj_tb;
  localparam int TW = 64;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [63:0] curTime = '0, reqTime = '0;
  logic [31:0] cycleTime = '0;
  logic        busy, done;
  logic [29:0] nsField;
  logic [31:0] secLo;
  logic [15:0] secHi;

  int nChk = 0;
  int nFail = 0;

  logic [29:0] expNs = '0;
  logic [31:0] expLo = '0;
  logic [15:0] expHi = '0;

  always #2 clk = ~clk;

  sched_base_time_adj u_dut (
    .clk(clk), .rstN(rstN), .start(start), .curTime(curTime),
    .reqTime(reqTime), .cycleTime(cycleTime), .busy(busy), .done(done),
    .nsField(nsField), .secLo(secLo), .secHi(secHi)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic checkOutputs(input string req);
    chk(nsField == expNs, req, 64'(nsField), 64'(expNs));
    chk(secLo == expLo, req, 64'(secLo), 64'(expLo));
    chk(secHi == expHi, req, 64'(secHi), 64'(expHi));
  endtask

  // reference model: placement rules, split and per-cycle timing
  task automatic runOp(input logic [63:0] cur, input logic [63:0] req,
                       input logic [31:0] cyc, input string tag, input bit inject);
    logic [63:0] cyc64, thr, el, rem, res, secs;
    bit useDiv;
    int lat;
    cyc64 = 64'(cyc);
    thr = cur + 2 * cyc64;
    useDiv = 1'b0;
    if (req >= thr) res = req;
    else if (req <= cur) begin
      el = cur - req;
      rem = 0;
      if (el > cyc64) begin
        rem = el % cyc64;
        useDiv = 1'b1;
      end
      res = thr + cyc64 - rem;
    end else res = req + 2 * cyc64;
    secs = res / 64'd1000000000;
    lat = useDiv ? (4 + 2 * TW) : (3 + TW);

    @(negedge clk);
    curTime = cur; reqTime = req; cycleTime = cyc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int n = 1; n <= lat + 1; n++) begin
      if (n == lat) begin
        expNs = 30'(res % 64'd1000000000);
        expLo = secs[31:0];
        expHi = secs[47:32];
      end
      chk(busy == (n < lat), "R5 busy", 64'(busy), 64'(n < lat));
      chk(done == (n == lat), (n == lat) ? "R6 done timing" : "R5 done pulse",
          64'(done), 64'(n == lat));
      checkOutputs((n == lat) ? tag : "R8 hold");
      if (inject && n == 5) begin
        start = 1'b1; curTime = 64'd77; reqTime = 64'd5; cycleTime = 32'd3;
      end else begin
        start = 1'b0;
      end
      if (n <= lat) @(negedge clk);
    end
  endtask

  initial begin
    logic [63:0] base;
    base = 64'd1700000000123456789;
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(busy == 1'b0, "R8 reset busy", 64'(busy), 0);
    chk(done == 1'b0, "R8 reset done", 64'(done), 0);
    checkOutputs("R8 reset fields");
    rstN = 1'b1;

    runOp(base, base + 64'd5000000, 32'd1000000, "R1 R4 future", 1'b0);
    runOp(base, base + 64'd2000000, 32'd1000000, "R1 R9 at threshold", 1'b0);
    runOp(base, base + 64'd1000000, 32'd1000000, "R3 between", 1'b0);
    runOp(base, base + 64'd1, 32'd1000000, "R3 just after now", 1'b0);
    runOp(base, base - 64'd123456789012, 32'd1000000, "R2 R4 past", 1'b0);
    runOp(base, base, 32'd250000, "R9 req equals now", 1'b0);
    runOp(base, base - 64'd250000, 32'd250000, "R9 elapsed equals cycle", 1'b0);
    runOp(base, base - 64'd750000, 32'd250000, "R9 multiple of cycle", 1'b0);
    runOp(base, 64'd0, 32'd999999999, "R2 max cycle", 1'b0);
    runOp(64'd5, 64'd3, 32'd1, "R2 tiny values", 1'b0);
    runOp(base, base - 64'd987654321, 32'd3333333, "R7 R2 start ignored", 1'b1);
    runOp(base, base + 64'd999, 32'd700, "R7 R3 start ignored", 1'b1);

    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL R5 watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  end
endmodule